// File: doc/BRIEF.md
# Selectable averaging RGB upsampler

This block doubles the pixel rate of a three-channel RGB stream. Pixels arrive at half the clock rate. For each pair of neighbouring input pixels the block emits the earlier pixel unchanged. It follows that pixel with a generated middle pixel. When interpolation is on, the middle pixel is the rounded mean of the two neighbours in each channel. When interpolation is off, the middle pixel is a copy of the earlier pixel. In both modes the output timing is the same, so logic further down the chain never sees a timing shift when the mode changes.

Interpolation is controlled by two sources: an external pin and a software bit. Both are active low. A software override bit picks which source is used. The chosen control is latched once per output pair, at the edge that captures a new input pixel. As a result, a change in the middle of a pair cannot affect that pair.

The block runs on one full-rate clock. An internal phase bit alternates on every edge. An input pixel is captured on every other edge, beginning with the first edge after reset. The `out_orig` flag marks the cycles that carry an unmodified input pixel. Before the first captured pixel, the held pixel is zero.

Top module: `upsmp_rgb`

## Requirements
- R1: While reset is asserted, all three output channels are 0 and `out_orig` is 0.
- R2: `out_orig` is 1 after the first clock edge after reset and then inverts on every edge.
- R3: An input pixel captured at edge 2n (edges counted from 0 after reset) appears unchanged on the outputs after edge 2n+2, with `out_orig` = 1. Before the first capture, the held pixel is 0.
- R4: With interpolation on, the output after edge 2n+3 is (a + b + 1) >> 1 in each channel, where a is the pixel captured at edge 2n and b is the pixel captured at edge 2n+2. The sum is formed without overflow, so 511 and 511 give 511.
- R5: With interpolation off, the output after an odd edge repeats the original pixel from the cycle before.
- R6: When `sw_override` = 1, `sw_interp_n` = 0 turns interpolation on and 1 turns it off. `pin_interp_n` is then ignored.
- R7: When `sw_override` = 0, `pin_interp_n` = 0 turns interpolation on and 1 turns it off. `sw_interp_n` is then ignored.
- R8: The control sources are sampled only at capture (even) edges. Their values at odd edges have no effect on the pair.
- R9: Input pixel values are sampled only at capture edges. Their values at odd edges have no effect.
- R10: The delay from capture to the original output is the same with interpolation on and off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Active-low reset; asynchronous assert, release synchronous to clk |
| in_r | input | 9 | Red input channel, sampled on capture edges |
| in_g | input | 9 | Green input channel |
| in_b | input | 9 | Blue input channel |
| pin_interp_n | input | 1 | External control, low enables interpolation |
| sw_interp_n | input | 1 | Register control, low enables interpolation |
| sw_override | input | 1 | 1 selects the register control, 0 selects the pin |
| out_r | output | 9 | Red output channel at full rate |
| out_g | output | 9 | Green output channel |
| out_b | output | 9 | Blue output channel |
| out_orig | output | 1 | 1 when the outputs carry an original pixel |

## Verification
A pixel captured at an even edge is due as the original output two edges later. Its middle partner is due one edge after that, and that partner uses the control value latched at the capture edge. The reference model in the bench advances on each rising edge, using the input values present at that edge. The bench compares outputs at the falling edge that follows, when every register has settled. Stimulus changes only after each comparison. In some phases the controls and pixel values change at odd edges as well, to show that the design ignores them there.

// File: rtl/upsmp_pkg.sv
package upsmp_pkg;

  localparam int unsigned NUM_CH = 3;

  typedef enum logic {
    SLOT_MID  = 1'b0,
    SLOT_ORIG = 1'b1
  } slot_e;

  // Resolve the active-low enable from the source picked by the override.
  function automatic logic interp_on(input logic ovr, input logic sw_n, input logic pin_n);
    return ovr ? ~sw_n : ~pin_n;
  endfunction

endpackage

// File: rtl/upsmp_ctrl.sv
module upsmp_ctrl
  import upsmp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin_interp_n,
  input  logic  sw_interp_n,
  input  logic  sw_override,
  output slot_e slot_q,
  output logic  take,
  output logic  mode_q
);

  slot_e slot_d;
  logic  mode_d;

  // The edge that leaves the middle slot is the capture edge.
  assign take = (slot_q == SLOT_MID);

  always_comb begin
    slot_d = take ? SLOT_ORIG : SLOT_MID;
    mode_d = mode_q;
    if (take) begin
      mode_d = interp_on(sw_override, sw_interp_n, pin_interp_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SLOT_MID;
      mode_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/upsmp_avg.sv
module upsmp_avg #(
  parameter int unsigned CH_W = 9
) (
  input  logic [CH_W-1:0] a,
  input  logic [CH_W-1:0] b,
  output logic [CH_W-1:0] y
);

  localparam int unsigned SUM_W = CH_W + 1;

  logic [SUM_W-1:0] sum;

  // One extra bit holds the carry; the added one rounds halves upward.
  assign sum = SUM_W'(a) + SUM_W'(b) + SUM_W'(1);
  assign y   = sum[SUM_W-1:1];

endmodule

// File: rtl/upsmp_rgb.sv
module upsmp_rgb
  import upsmp_pkg::*;
#(
  parameter int unsigned CH_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_W-1:0] in_r,
  input  logic [CH_W-1:0] in_g,
  input  logic [CH_W-1:0] in_b,
  input  logic            pin_interp_n,
  input  logic            sw_interp_n,
  input  logic            sw_override,
  output logic [CH_W-1:0] out_r,
  output logic [CH_W-1:0] out_g,
  output logic [CH_W-1:0] out_b,
  output logic            out_orig
);

  localparam int unsigned PIX_W = NUM_CH * CH_W;

  slot_e                          slot_q;
  logic                           take;
  logic                           mode_q;
  logic [NUM_CH-1:0][CH_W-1:0]    pix_in_a;
  logic [NUM_CH-1:0][CH_W-1:0]    cur_q, cur_d;
  logic [NUM_CH-1:0][CH_W-1:0]    out_q, out_d;
  logic [NUM_CH-1:0][CH_W-1:0]    mid_a;
  logic [PIX_W-1:0]               pix_in_flat;
  logic [PIX_W-1:0]               pix_out_flat;

  assign pix_in_a = {in_r, in_g, in_b};

  upsmp_ctrl i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_interp_n (pin_interp_n),
    .sw_interp_n  (sw_interp_n),
    .sw_override  (sw_override),
    .slot_q       (slot_q),
    .take         (take),
    .mode_q       (mode_q)
  );

  // Middle pixel: the original on the output now, blended with the newest capture.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    upsmp_avg #(.CH_W(CH_W)) i_avg (
      .a (out_q[c]),
      .b (cur_q[c]),
      .y (mid_a[c])
    );
  end

  always_comb begin
    cur_d = cur_q;
    out_d = out_q;
    if (take) begin
      cur_d = pix_in_a;
      out_d = cur_q;
    end else if (mode_q) begin
      out_d = mid_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      out_q <= '0;
    end else begin
      cur_q <= cur_d;
      out_q <= out_d;
    end
  end

  assign {out_r, out_g, out_b} = out_q;
  assign out_orig              = (slot_q == SLOT_ORIG);
  assign pix_in_flat           = pix_in_a;
  assign pix_out_flat          = out_q;

endmodule

// File: rtl/upsmp_rgb_chk.sv
module upsmp_rgb_chk #(
  parameter int unsigned PIX_W = 27
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_orig,
  input logic             mode_q,
  input logic             sw_override,
  input logic             sw_interp_n,
  input logic             pin_interp_n,
  input logic [PIX_W-1:0] pix_in,
  input logic [PIX_W-1:0] pix_out
);

  logic [1:0] edges_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges_q <= 2'd0;
    end else if (edges_q != 2'd3) begin
      edges_q <= edges_q + 2'd1;
    end
  end

  AST_ORIG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_orig |=> out_orig); // R2
  AST_ORIG_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_orig |=> !out_orig); // R2
  AST_ORIG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q >= 2'd2) && !out_orig |=> pix_out == $past(pix_in, 3)); // R3
  AST_BYPASS_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_orig && !mode_q |=> pix_out == $past(pix_out)); // R5
  AST_SRC_SW: assert property (@(posedge clk) disable iff (!rst_n)
    !out_orig && sw_override |=> mode_q == !$past(sw_interp_n)); // R6
  AST_SRC_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !out_orig && !sw_override |=> mode_q == !$past(pin_interp_n)); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_orig |=> $stable(mode_q)); // R8

endmodule

bind upsmp_rgb upsmp_rgb_chk #(.PIX_W(PIX_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .out_orig     (out_orig),
  .mode_q       (mode_q),
  .sw_override  (sw_override),
  .sw_interp_n  (sw_interp_n),
  .pin_interp_n (pin_interp_n),
  .pix_in       (pix_in_flat),
  .pix_out      (pix_out_flat)
);

// File: tb/test_upsmp_rgb.sv
module test_upsmp_rgb;

  logic       clk;
  logic       rst_n;
  logic [8:0] in_r, in_g, in_b;
  logic       pin_interp_n, sw_interp_n, sw_override;
  logic [8:0] out_r, out_g, out_b;
  logic       out_orig;

  int errors = 0;
  int checks = 0;
  int edge_k = 0;
  int m_cur[3];
  int m_out[3];
  int m_orig = 0;
  int m_mode = 0;

  upsmp_rgb i_upsmp_rgb (
    .clk(clk), .rst_n(rst_n), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .pin_interp_n(pin_interp_n), .sw_interp_n(sw_interp_n), .sw_override(sw_override),
    .out_r(out_r), .out_g(out_g), .out_b(out_b), .out_orig(out_orig)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual=%0d expected=%0d", req, what, edge_k, act, exp);
    end
  endtask

  // Reference: even edges capture and show the prior capture; odd edges show the middle pixel.
  task automatic step(input string ph);
    int nw[3];
    string tag;
    @(posedge clk);
    nw[0] = in_r; nw[1] = in_g; nw[2] = in_b;
    if (edge_k % 2 == 0) begin
      m_mode = sw_override ? !sw_interp_n : !pin_interp_n;
      for (int c = 0; c < 3; c++) begin
        m_out[c] = m_cur[c];
        m_cur[c] = nw[c];
      end
      m_orig = 1;
    end else begin
      for (int c = 0; c < 3; c++)
        if (m_mode != 0) m_out[c] = (m_out[c] + m_cur[c] + 1) / 2;
      m_orig = 0;
    end
    edge_k++;
    @(negedge clk);
    if (m_orig != 0) tag = "R3/R10";
    else if (m_mode != 0) tag = "R4";
    else tag = "R5";
    chk(out_r, m_out[0], tag, {ph, " red"});
    chk(out_g, m_out[1], tag, {ph, " green"});
    chk(out_b, m_out[2], tag, {ph, " blue"});
    chk(out_orig, m_orig, "R2", {ph, " orig flag"});
  endtask

  task automatic rnd_pix();
    in_r = 9'($urandom); in_g = 9'($urandom); in_b = 9'($urandom);
  endtask

  initial begin
    int corner[8] = '{511, 510, 0, 1, 511, 511, 0, 511};
    for (int c = 0; c < 3; c++) begin m_cur[c] = 0; m_out[c] = 0; end
    rst_n = 1'b0;
    in_r = 9'd5; in_g = 9'd6; in_b = 9'd7;
    pin_interp_n = 1'b0; sw_interp_n = 1'b1; sw_override = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_r, 0, "R1", "reset red");
    chk(out_g, 0, "R1", "reset green");
    chk(out_b, 0, "R1", "reset blue");
    chk(out_orig, 0, "R1", "reset flag");
    rst_n = 1'b1;

    // R4: interpolation from the pin, corner values on red
    for (int i = 0; i < 8; i++) begin
      in_r = 9'(corner[i]); in_g = 9'($urandom); in_b = 9'(corner[7 - i]);
      step("R4 corners"); step("R4 corners");
    end
    for (int i = 0; i < 12; i++) begin
      if (edge_k % 2 == 0) rnd_pix();
      step("R4 random");
    end
    // R5: bypass from the pin
    pin_interp_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (edge_k % 2 == 0) rnd_pix();
      step("R5 bypass");
    end
    // R7: pin selects, software bit toggles freely
    for (int i = 0; i < 24; i++) begin
      if (edge_k % 2 == 0) begin rnd_pix(); pin_interp_n = 1'($urandom); end
      sw_interp_n = 1'($urandom);
      step("R7 pin source");
    end
    // R6: software selects, pin toggles freely
    sw_override = 1'b1;
    for (int i = 0; i < 24; i++) begin
      if (edge_k % 2 == 0) begin rnd_pix(); sw_interp_n = 1'($urandom); end
      pin_interp_n = 1'($urandom);
      step("R6 sw source");
    end
    // R8: controls change every cycle, including at odd edges
    for (int i = 0; i < 40; i++) begin
      if (edge_k % 2 == 0) rnd_pix();
      sw_override = 1'($urandom); sw_interp_n = 1'($urandom); pin_interp_n = 1'($urandom);
      step("R8 mid-pair control");
    end
    // R9: pixel values change at odd edges too
    sw_override = 1'b0; pin_interp_n = 1'b0;
    for (int i = 0; i < 40; i++) begin
      rnd_pix();
      if (i == 20) pin_interp_n = 1'b1;
      step("R9 mid-pair pixels");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule